// File: doc/BRIEF.md
# Masked HDLC Station Address Filter

This block sits between an HDLC receiver and the logic that stores frame data. It decides whether a received frame is addressed to this station. The first two bytes after the opening flag form a 16-bit address. The byte that arrives first lands in the low half. The assembled address is checked against four station address entries under one shared bit mask. If any entry agrees in every compared position, the frame is accepted and forwarded byte for byte, and its last byte is marked together with the receiver's frame-good verdict.

Address bytes are held inside the block until the decision is known, so nothing from a rejected frame ever reaches the output. A frame that is rejected and that the receiver reports as error-free at its end raises a one-cycle event for the statistics logic.

Clearing the upper eight mask bits turns the block into an 8-bit address filter. A mask of all zeros admits every frame that carries at least two bytes.

Input handshake rules:
- The receiver marks the first byte of a frame with `rx_first`.
- It gives `rx_end` in a cycle of its own, after the last byte.
- It leaves at least one idle cycle between the end of one frame and the first byte of the next.

Top module: `hdlc_addr_filter`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `flt_vld`, `flt_last`, `flt_good` and `nomatch_evt` are all low.
- R2: The first byte of a frame fills address bits 7:0 and the second fills bits 15:8. With mask 0xFFFF, a frame starting 0x68, 0xAA matches an entry holding 0xAA68, and a frame starting 0xAA, 0x68 does not.
- R3: Entry k of `cfg_addr` sits in bits 16k+15:16k, for k = 0 to 3. A match on any single entry accepts the frame.
- R4: A mask bit of 1 makes that address bit take part in the comparison. A mask bit of 0 makes it ignored.
- R5: With mask 0x00FF, only the first address byte decides, and the second byte may hold any value.
- R6: With mask 0x0000, every frame of two or more bytes is accepted.
- R7: An accepted frame is forwarded whole and in order, address bytes included, one output byte per input byte. Timing of the forwarded bytes:
  - The first byte is output in the cycle after the second byte is sampled.
  - Each later body byte is output in the cycle after the next input byte is sampled.
  - The final byte is output in the cycle after `rx_end`, with `flt_last` high and `flt_good` equal to `rx_good`.
- R8: A rejected frame produces no `flt_vld` at all, and no accepted frame raises `nomatch_evt`.
- R9: A rejected frame whose end comes with `rx_good` high raises `nomatch_evt` for one cycle, in the cycle after `rx_end`. With `rx_good` low, no event is raised.
- R10: A frame that ends after fewer than two bytes is treated as a mismatch, even with mask 0x0000. It raises the event of R9 only if it ends good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_vld | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_first | input | 1 | Marks the first byte after the opening flag |
| rx_end | input | 1 | Frame end strobe, in a cycle without a byte |
| rx_good | input | 1 | Frame error-free verdict, valid with `rx_end` |
| cfg_mask | input | 16 | Shared comparison mask, 1 = compare |
| cfg_addr | input | 64 | Four station address entries, entry k in bits 16k+15:16k |
| flt_vld | output | 1 | Forwarded byte strobe |
| flt_byte | output | 8 | Forwarded byte |
| flt_last | output | 1 | Marks the final byte of a forwarded frame |
| flt_good | output | 1 | Frame verdict, valid with `flt_last` |
| nomatch_evt | output | 1 | One-cycle pulse: an error-free frame was rejected |

## Verification
The hardest case to reach from the ports is the timing of the forwarded stream. Every output byte waits one input byte behind, and the final byte leaves only when the end strobe arrives. A gap in the input therefore shifts every later output cycle. The stimulus sends accepted frames with irregular idle gaps between bytes. For each byte, it records the cycle in which that byte should emerge, computed from the drive cycle of the byte that releases it.

Short frames, reversed address bytes and masks that hide or expose a single differing bit are also sent. They confirm where accept and reject separate, and that only error-free rejects raise the event.

// File: rtl/hdlc_af_pkg.sv
package hdlc_af_pkg;

  // Per-frame progress of the address decision
  typedef enum logic [1:0] {
    ST_IDLE,  // between frames
    ST_ADDR,  // collecting address bytes
    ST_PASS,  // accepted, forwarding
    ST_DROP   // rejected, discarding
  } af_state_t;

  // Frame-end notice from control to output stage
  typedef struct packed {
    logic go;
    logic ok;
  } af_end_t;

endpackage

// File: rtl/hdlc_af_match.sv
module hdlc_af_match #(
  parameter int N_ADDR = 4,
  parameter int AW     = 16
) (
  input  logic [AW-1:0]        addr,
  input  logic [AW-1:0]        mask,
  input  logic [N_ADDR*AW-1:0] tbl,
  output logic                 hit
);

  logic [N_ADDR-1:0] eq;

  // One comparator per station entry, compared only where mask is set
  for (genvar g = 0; g < N_ADDR; g++) begin : g_cmp
    assign eq[g] = ((addr ^ tbl[g*AW +: AW]) & mask) == '0;
  end

  assign hit = |eq;

endmodule

// File: rtl/hdlc_af_ctrl.sv
module hdlc_af_ctrl
  import hdlc_af_pkg::*;
#(
  parameter int AW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_vld,
  input  logic [BW-1:0] rx_byte,
  input  logic          rx_first,
  input  logic          rx_end,
  input  logic          rx_good,
  input  logic          hit,
  output logic [AW-1:0] addr_now,
  output logic          dec_pass,
  output logic          fwd_vld,
  output logic [BW-1:0] fwd_byte,
  output af_end_t       end_pass,
  output logic          nomatch_evt
);

  localparam int NB = AW / BW;
  localparam int CW = $clog2(NB + 1);

  af_state_t      st;
  logic [AW-1:0]  hold;
  logic [CW-1:0]  cnt;
  logic [CW-1:0]  idx;
  logic           take;
  logic           full;

  // Position of the incoming byte within the address
  assign idx  = rx_first ? '0 : cnt;
  assign take = rx_vld && (rx_first || st == ST_ADDR);
  assign full = take && (idx == CW'(NB - 1));

  // Address as it stands with the current byte inserted
  always_comb begin
    addr_now = rx_first ? '0 : hold;
    for (int b = 0; b < NB; b++) begin
      if (idx == CW'(b)) addr_now[b*BW +: BW] = rx_byte;
    end
  end

  assign dec_pass    = full && hit;
  assign fwd_vld     = rx_vld && !rx_first && st == ST_PASS;
  assign fwd_byte    = rx_byte;
  assign end_pass.go = rx_end && !take && st == ST_PASS;
  assign end_pass.ok = rx_good;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      hold        <= '0;
      cnt         <= '0;
      nomatch_evt <= 1'b0;
    end else begin
      nomatch_evt <= 1'b0;
      if (take) begin
        hold <= addr_now;
        cnt  <= idx + CW'(1);
        if (full) st <= hit ? ST_PASS : ST_DROP;
        else      st <= ST_ADDR;
      end else if (rx_end) begin
        if (st == ST_ADDR || st == ST_DROP) nomatch_evt <= rx_good;
        st  <= ST_IDLE;
        cnt <= '0;
      end
    end
  end

endmodule

// File: rtl/hdlc_af_emit.sv
module hdlc_af_emit
  import hdlc_af_pkg::*;
#(
  parameter int AW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dec_pass,
  input  logic [AW-1:0] addr_now,
  input  logic          fwd_vld,
  input  logic [BW-1:0] fwd_byte,
  input  af_end_t       end_pass,
  output logic          o_vld,
  output logic [BW-1:0] o_byte,
  output logic          o_last,
  output logic          o_good
);

  localparam int NB = AW / BW;
  localparam int PD = NB - 1;          // bytes kept one step behind
  localparam int CW = $clog2(NB + 1);

  logic [BW-1:0] pend [PD];
  logic [CW-1:0] fill;
  logic          drain;
  logic          ok_l;
  logic          ok_now;

  assign ok_now = end_pass.go ? end_pass.ok : ok_l;

  always_ff @(posedge clk) begin
    if (rst) begin
      o_vld  <= 1'b0;
      o_byte <= '0;
      o_last <= 1'b0;
      o_good <= 1'b0;
      fill   <= '0;
      drain  <= 1'b0;
      ok_l   <= 1'b0;
      for (int k = 0; k < PD; k++) pend[k] <= '0;
    end else begin
      o_vld  <= 1'b0;
      o_last <= 1'b0;
      o_good <= 1'b0;
      if (dec_pass) begin
        // release the lowest address byte, keep the rest
        o_vld  <= 1'b1;
        o_byte <= addr_now[0 +: BW];
        for (int k = 0; k < PD; k++) pend[k] <= addr_now[(k+1)*BW +: BW];
        fill   <= CW'(PD);
        drain  <= 1'b0;
      end else if (fwd_vld) begin
        o_vld  <= 1'b1;
        o_byte <= pend[0];
        for (int k = 0; k < PD - 1; k++) pend[k] <= pend[k+1];
        pend[PD-1] <= fwd_byte;
      end else if (end_pass.go || drain) begin
        o_vld  <= 1'b1;
        o_byte <= pend[0];
        for (int k = 0; k < PD - 1; k++) pend[k] <= pend[k+1];
        fill   <= fill - CW'(1);
        ok_l   <= ok_now;
        if (fill == CW'(1)) begin
          o_last <= 1'b1;
          o_good <= ok_now;
          drain  <= 1'b0;
        end else begin
          drain  <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter
  import hdlc_af_pkg::*;
#(
  parameter int N_ADDR = 4,
  parameter int AW     = 16,
  parameter int BW     = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_vld,
  input  logic [BW-1:0]        rx_byte,
  input  logic                 rx_first,
  input  logic                 rx_end,
  input  logic                 rx_good,
  input  logic [AW-1:0]        cfg_mask,
  input  logic [N_ADDR*AW-1:0] cfg_addr,
  output logic                 flt_vld,
  output logic [BW-1:0]        flt_byte,
  output logic                 flt_last,
  output logic                 flt_good,
  output logic                 nomatch_evt
);

  logic [AW-1:0] addr_now;
  logic          hit;
  logic          dec_pass;
  logic          fwd_vld;
  logic [BW-1:0] fwd_byte;
  af_end_t       end_pass;

  hdlc_af_match #(.N_ADDR(N_ADDR), .AW(AW)) u_match (
    .addr (addr_now),
    .mask (cfg_mask),
    .tbl  (cfg_addr),
    .hit  (hit)
  );

  hdlc_af_ctrl #(.AW(AW), .BW(BW)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .rx_vld      (rx_vld),
    .rx_byte     (rx_byte),
    .rx_first    (rx_first),
    .rx_end      (rx_end),
    .rx_good     (rx_good),
    .hit         (hit),
    .addr_now    (addr_now),
    .dec_pass    (dec_pass),
    .fwd_vld     (fwd_vld),
    .fwd_byte    (fwd_byte),
    .end_pass    (end_pass),
    .nomatch_evt (nomatch_evt)
  );

  hdlc_af_emit #(.AW(AW), .BW(BW)) u_emit (
    .clk      (clk),
    .rst      (rst),
    .dec_pass (dec_pass),
    .addr_now (addr_now),
    .fwd_vld  (fwd_vld),
    .fwd_byte (fwd_byte),
    .end_pass (end_pass),
    .o_vld    (flt_vld),
    .o_byte   (flt_byte),
    .o_last   (flt_last),
    .o_good   (flt_good)
  );

endmodule

// File: rtl/hdlc_af_chk.sv
module hdlc_af_chk (
  input logic clk,
  input logic rst,
  input logic rx_vld,
  input logic rx_end,
  input logic rx_good,
  input logic flt_vld,
  input logic flt_last,
  input logic flt_good,
  input logic nomatch_evt
);

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  always @(negedge clk) begin
    if (rst_q) begin
      AST_RESET_QUIET: assert (!flt_vld && !flt_last && !flt_good && !nomatch_evt); // R1
    end
  end

  AST_EVT_AFTER_GOOD_END: assert property (@(posedge clk) disable iff (rst)
    nomatch_evt |-> $past(rx_end && rx_good)); // R9

  AST_BODY_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
    (flt_vld && !flt_last) |-> $past(rx_vld)); // R7

  AST_LAST_AFTER_END: assert property (@(posedge clk) disable iff (rst)
    (flt_vld && flt_last) |-> $past(rx_end)); // R7

  AST_GOOD_ONLY_ON_LAST: assert property (@(posedge clk) disable iff (rst)
    flt_good |-> (flt_vld && flt_last)); // R7

  AST_NO_FWD_WITH_EVT: assert property (@(posedge clk) disable iff (rst)
    !(flt_vld && nomatch_evt)); // R8

endmodule

bind hdlc_addr_filter hdlc_af_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .rx_vld      (rx_vld),
  .rx_end      (rx_end),
  .rx_good     (rx_good),
  .flt_vld     (flt_vld),
  .flt_last    (flt_last),
  .flt_good    (flt_good),
  .nomatch_evt (nomatch_evt)
);

// File: tb/test_hdlc_addr_filter.sv
module test_hdlc_addr_filter;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_vld = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_first = 1'b0;
  logic        rx_end = 1'b0;
  logic        rx_good = 1'b0;
  logic [15:0] cfg_mask = 16'hFFFF;
  logic [63:0] cfg_addr;
  logic        flt_vld, flt_last, flt_good, nomatch_evt;
  logic [7:0]  flt_byte;

  logic [15:0] tbl [4];
  assign cfg_addr = {tbl[3], tbl[2], tbl[1], tbl[0]};

  always #4 clk = ~clk;  // 125 MHz

  hdlc_addr_filter i_hdlc_addr_filter (
    .clk(clk), .rst(rst), .rx_vld(rx_vld), .rx_byte(rx_byte),
    .rx_first(rx_first), .rx_end(rx_end), .rx_good(rx_good),
    .cfg_mask(cfg_mask), .cfg_addr(cfg_addr),
    .flt_vld(flt_vld), .flt_byte(flt_byte), .flt_last(flt_last),
    .flt_good(flt_good), .nomatch_evt(nomatch_evt)
  );

  typedef struct {
    logic [7:0] b;
    logic       last;
    logic       good;
    int         cyc;
    string      req;
  } item_t;

  item_t exp_q[$];
  int    rej_q[$];
  string rej_tag[$];
  logic [7:0] fb[$];
  int    cyc = 0;
  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit ref_hit(input logic [7:0] b0, input logic [7:0] b1);
    logic [15:0] a;
    a = {b1, b0};
    for (int k = 0; k < 4; k++)
      if (((a ^ tbl[k]) & cfg_mask) == 16'h0) return 1'b1;
    return 1'b0;
  endfunction

  // Driver: sends fb[] as one frame and queues what must come out
  task automatic send_frame(input bit good, input int gap, input string req);
    bit pass;
    int c;
    int n;
    n = fb.size();
    pass = (n >= 2) && ref_hit(fb[0], fb[1]);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      rx_vld = 1'b1; rx_byte = fb[j]; rx_first = (j == 0);
      c = cyc;
      if (pass && j == 1) exp_q.push_back('{fb[0], 1'b0, 1'b0, c + 1, req});
      if (pass && j >= 2) exp_q.push_back('{fb[j-1], 1'b0, 1'b0, c + 1, req});
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        rx_vld = 1'b0; rx_first = 1'b0;
      end
    end
    @(negedge clk);
    rx_vld = 1'b0; rx_first = 1'b0; rx_end = 1'b1; rx_good = good;
    c = cyc;
    if (pass) exp_q.push_back('{fb[n-1], 1'b1, good, c + 1, req});
    else if (good) begin
      rej_q.push_back(c + 1);
      rej_tag.push_back(req);
    end
    @(negedge clk);
    rx_end = 1'b0; rx_good = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (flt_vld) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8", "unexpected forwarded byte", flt_byte, 0);
        end else begin
          item_t e;
          e = exp_q.pop_front();
          chk(flt_byte == e.b, e.req, "byte", flt_byte, e.b);
          chk(flt_last == e.last, e.req, "last flag", flt_last, e.last);
          chk(flt_good == e.good, e.req, "good flag", flt_good, e.good);
          chk(cyc == e.cyc, "R7", "output cycle", cyc, e.cyc);
        end
      end else if (flt_last || flt_good) begin
        chk(1'b0, "R7", "flag without byte", {flt_last, flt_good}, 0);
      end
      if (nomatch_evt) begin
        if (rej_q.size() == 0) begin
          chk(1'b0, "R9", "unexpected nomatch event", 1, 0);
        end else begin
          int ec;
          string tg;
          ec = rej_q.pop_front();
          tg = rej_tag.pop_front();
          chk(cyc == ec, tg, "nomatch event cycle", cyc, ec);
        end
      end
    end
  end

  task automatic finish_run;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    tbl[0] = 16'hAA68; tbl[1] = 16'h1234; tbl[2] = 16'hBEEF; tbl[3] = 16'h0F0F;
    cfg_mask = 16'hFFFF;
    repeat (3) @(negedge clk);
    // R1: quiet during reset
    chk(!flt_vld && !flt_last && !flt_good && !nomatch_evt, "R1", "outputs in reset",
        {flt_vld, flt_last, flt_good, nomatch_evt}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!flt_vld && !nomatch_evt, "R1", "outputs after reset",
        {flt_vld, nomatch_evt}, 0);

    // R2: low byte first, entry 0
    fb = '{8'h68, 8'hAA, 8'h01, 8'h02, 8'h03}; send_frame(1'b1, 0, "R2");
    // R2: reversed order rejected, event
    fb = '{8'hAA, 8'h68, 8'h01};               send_frame(1'b1, 0, "R2");
    // R3: entry 1, bad frame forwarded with good low
    fb = '{8'h34, 8'h12, 8'h55};               send_frame(1'b0, 0, "R3");
    // R3: entry 2, address only
    fb = '{8'hEF, 8'hBE};                      send_frame(1'b1, 0, "R3");
    // R7: entry 3 with gaps between bytes
    fb = '{8'h0F, 8'h0F, 8'h99, 8'h98};        send_frame(1'b1, 2, "R7");
    fb = '{8'h0F, 8'h0F, 8'h11, 8'h22, 8'h33}; send_frame(1'b0, 1, "R7");
    // R9: mismatch with errors, no event
    fb = '{8'h00, 8'h00, 8'h11};               send_frame(1'b0, 0, "R9");
    // R10: single-byte frames
    fb = '{8'h68};                             send_frame(1'b1, 0, "R10");
    fb = '{8'h68};                             send_frame(1'b0, 0, "R10");

    // R5: 8-bit mode
    cfg_mask = 16'h00FF;
    fb = '{8'h68, 8'h00, 8'h07};               send_frame(1'b1, 0, "R5");
    fb = '{8'h68, 8'hFF};                      send_frame(1'b0, 1, "R5");
    fb = '{8'h69, 8'hAA};                      send_frame(1'b1, 0, "R5");

    // R4: partial mask
    cfg_mask = 16'hF0F0;
    fb = '{8'h6F, 8'hA5, 8'h44};               send_frame(1'b1, 0, "R4");
    fb = '{8'h78, 8'hAA, 8'h44};               send_frame(1'b1, 0, "R4");

    // R6: mask zero
    cfg_mask = 16'h0000;
    fb = '{8'h12, 8'h34, 8'h56};               send_frame(1'b1, 0, "R6");
    fb = '{8'hFF, 8'hFF};                      send_frame(1'b1, 3, "R6");
    fb = '{8'h12};                             send_frame(1'b1, 0, "R10");

    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0, "R7", "forwarded bytes missing", exp_q.size(), 0);
    chk(rej_q.size() == 0, "R9", "nomatch events missing", rej_q.size(), 0);
    finish_run();
  end

endmodule